// File: doc/BRIEF.md
# Register Rename Stage

This block renames a dispatch group of W instructions in one cycle. Each instruction brings two architectural source numbers, one architectural destination number and a valid bit. The block looks up the physical tag of each source in a register alias table, allocates a fresh physical tag for each destination from a free list, and returns the mapping each destination had before the group, so that a later recovery step can restore it.

The table reads for all sources start together, as if no instruction in the group depended on another. At the same time, every destination is compared against the sources of the instructions that follow it in the group. When a source is written by an earlier instruction of the same group, its table read is switched off, and the source takes the producer's new tag instead. A per-source read-enable output shows which reads actually took place.

Architectural register 0 is hardwired: it is never looked up, compared or given a tag. The group is accepted only while the free list holds at least W tags. Results appear on registered outputs one cycle after the group is accepted.

Top module: `rename_stage`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1. Every architectural register i maps to physical tag i. The free list hands out tags in ascending order, starting at ARCH_REGS.
- R2: A valid source with a nonzero number and no earlier writer in its group gets the table's current mapping, and its read-enable bit is 1.
- R3: A source written by an earlier valid instruction of the same group gets that producer's newly allocated tag, and its read-enable bit is 0.
- R4: When several earlier instructions in the group write a source's register, the nearest preceding writer supplies the tag.
- R5: Every valid instruction with a nonzero destination receives the next free tag. Tags go out in slot order, slot 0 first.
- R6: The old-mapping output of an allocating instruction is the nearest earlier in-group writer's new tag for the same register, or the table's mapping when there is no such writer.
- R7: When several instructions in a group write the same register, later groups read the tag of the youngest of those writers.
- R8: A source numbered 0 yields tag 0 with read-enable 0. A destination numbered 0 allocates nothing and yields a new tag of 0 and an old mapping of 0.
- R9: inReady is 0 whenever fewer than W tags are free. While inReady is 0, a presented group produces no output and allocates nothing.
- R10: An invalid slot allocates nothing. All of its tag outputs and read-enable bits are 0, and its outInstValid bit is 0.
- R11: outValid rises exactly one cycle after a group is accepted, and it goes high once per accepted group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A group is presented |
| inReady | output | 1 | At least W free tags are available; the group is accepted when inValid and inReady are both high |
| instValid | input | W | Per-slot instruction valid |
| srcA | input | W*AW | First source number per slot; slot k is at bits [k*AW +: AW] |
| srcB | input | W*AW | Second source number per slot |
| dst | input | W*AW | Destination number per slot |
| outValid | output | 1 | Renamed group is present |
| outInstValid | output | W | Per-slot valid of the renamed group |
| outSrcTagA | output | W*PW | Physical tag of the first source; slot k is at [k*PW +: PW] |
| outSrcTagB | output | W*PW | Physical tag of the second source |
| outReadEnA | output | W | Table read of the first source took place |
| outReadEnB | output | W | Table read of the second source took place |
| outDstTag | output | W*PW | Newly allocated destination tag |
| outOldTag | output | W*PW | Previous mapping of the destination, kept for checkpointing |

## Verification
The bench builds the block with W=4, 16 architectural registers and 64 physical registers. This leaves 48 free tags, which is enough for directed groups on chains, repeated writers and register 0, plus a run of random groups. The run continues until fewer than four tags remain, so the stall condition is reached in a short run. With only 16 architectural numbers, random groups often collide within a group, and that exercises the nearest-writer selection and the youngest-writer update.

// File: rtl/rename_pkg.sv
package rename_pkg;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic fire;      // group accepted this cycle: pop tags, write table
    logic outLoad;   // capture renamed results into output registers
    logic outClear;  // clear output registers
  } renameStrobe_t;

endpackage

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int W = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 96,
  localparam int DEPTH = PHYS_REGS - ARCH_REGS,
  localparam int PW = $clog2(PHYS_REGS),
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            popEn,
  input  logic [NW-1:0]   popCnt,
  output logic [W*PW-1:0] peekTags,
  output logic [CW-1:0]   freeCount
);

  logic [PW-1:0] tagStore [DEPTH];
  logic [IW-1:0] head;
  logic [IW:0]   nextHead;

  // Tag storage: filled with the non-architectural tags at reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tagStore[i] <= PW'(ARCH_REGS + i);
    end
  end

  // The next W entries from the head, wrapping around the store
  generate
    for (genvar j = 0; j < W; j++) begin : g_peek
      logic [IW:0] idx;
      always_comb begin
        idx = (IW+1)'(head) + (IW+1)'(j);
        if (idx >= (IW+1)'(DEPTH)) idx = idx - (IW+1)'(DEPTH);
      end
      assign peekTags[j*PW +: PW] = tagStore[idx[IW-1:0]];
    end
  endgenerate

  always_comb begin
    nextHead = (IW+1)'(head) + (IW+1)'(popCnt);
    if (nextHead >= (IW+1)'(DEPTH)) nextHead = nextHead - (IW+1)'(DEPTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      freeCount <= CW'(DEPTH);
    end else if (popEn) begin
      head      <= nextHead[IW-1:0];
      freeCount <= freeCount - CW'(popCnt);
    end
  end

  // R9
  always @(posedge clk) begin
    if (!rst && popEn) begin
      no_underflow_chk: assert (CW'(popCnt) <= freeCount)
        else $error("free list popped below empty");
    end
  end

  // R9
  hold_count_chk: assert property (@(posedge clk) disable iff (rst)
    !popEn |=> $stable(freeCount));

endmodule

// File: rtl/rename_ctrl.sv
module rename_ctrl import rename_pkg::*; #(
  parameter int W = 4,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [CW-1:0] freeCount,
  output logic          inReady,
  output renameStrobe_t strobe,
  output logic          outValid
);

  logic fire;

  assign inReady = (int'(freeCount) >= W);
  assign fire    = inValid && inReady;

  always_comb begin
    strobe.fire     = fire;
    strobe.outLoad  = fire;
    strobe.outClear = !fire;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= fire;
  end

  // R9
  stall_out_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !inReady) |=> !outValid);

  // R11
  accept_out_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> outValid);

endmodule

// File: rtl/rename_datapath.sv
module rename_datapath import rename_pkg::*; #(
  parameter int W = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 96,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int NW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  renameStrobe_t   strobe,
  input  logic [W-1:0]    instValid,
  input  logic [W*AW-1:0] srcA,
  input  logic [W*AW-1:0] srcB,
  input  logic [W*AW-1:0] dst,
  input  logic [W*PW-1:0] peekTags,
  output logic [NW-1:0]   popCnt,
  output logic [W-1:0]    outInstValid,
  output logic [W*PW-1:0] outSrcTagA,
  output logic [W*PW-1:0] outSrcTagB,
  output logic [W-1:0]    outReadEnA,
  output logic [W-1:0]    outReadEnB,
  output logic [W*PW-1:0] outDstTag,
  output logic [W*PW-1:0] outOldTag
);

  logic [PW-1:0] mapTab [ARCH_REGS];

  logic [AW-1:0] srcAArr [W];
  logic [AW-1:0] srcBArr [W];
  logic [AW-1:0] dstArr  [W];
  logic [W-1:0]  alloc;
  logic [NW-1:0] slotOff [W];
  logic [PW-1:0] newTag  [W];
  logic [PW-1:0] tagA    [W];
  logic [PW-1:0] tagB    [W];
  logic [PW-1:0] oldTag  [W];
  logic [W-1:0]  readA;
  logic [W-1:0]  readB;

  generate
    for (genvar k = 0; k < W; k++) begin : g_unpack
      assign srcAArr[k] = srcA[k*AW +: AW];
      assign srcBArr[k] = srcB[k*AW +: AW];
      assign dstArr[k]  = dst[k*AW +: AW];
    end
  endgenerate

  // Allocation: allocating slots take consecutive tags, in slot order
  always_comb begin
    logic [NW-1:0] run;
    run = '0;
    for (int k = 0; k < W; k++) begin
      alloc[k]   = instValid[k] && (dstArr[k] != '0);
      slotOff[k] = run;
      newTag[k]  = alloc[k] ? peekTags[int'(run)*PW +: PW] : '0;
      if (alloc[k]) run = run + NW'(1);
    end
    popCnt = run;
  end

  // Source translation. The table read is assumed first; an earlier
  // in-group writer overrides it, with later slots taking precedence.
  always_comb begin
    for (int k = 0; k < W; k++) begin
      tagA[k]   = mapTab[srcAArr[k]];
      readA[k]  = 1'b1;
      tagB[k]   = mapTab[srcBArr[k]];
      readB[k]  = 1'b1;
      oldTag[k] = mapTab[dstArr[k]];
      if (!instValid[k] || srcAArr[k] == '0) begin
        tagA[k]  = '0;
        readA[k] = 1'b0;
      end
      if (!instValid[k] || srcBArr[k] == '0) begin
        tagB[k]  = '0;
        readB[k] = 1'b0;
      end
      if (!alloc[k]) oldTag[k] = '0;
      for (int j = 0; j < k; j++) begin
        if (alloc[j] && readA[k] && dstArr[j] == srcAArr[k]) begin
          tagA[k] = newTag[j];
        end
        if (alloc[j] && readB[k] && dstArr[j] == srcBArr[k]) begin
          tagB[k] = newTag[j];
        end
        if (alloc[j] && alloc[k] && dstArr[j] == dstArr[k]) begin
          oldTag[k] = newTag[j];
        end
      end
    end
    // Reads with an in-group producer are gated off
    for (int k = 0; k < W; k++) begin
      for (int j = 0; j < k; j++) begin
        if (alloc[j] && instValid[k] && srcAArr[k] != '0 && dstArr[j] == srcAArr[k]) readA[k] = 1'b0;
        if (alloc[j] && instValid[k] && srcBArr[k] != '0 && dstArr[j] == srcBArr[k]) readB[k] = 1'b0;
      end
    end
  end

  // Alias table update: slots are written in order, so the youngest writer wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) mapTab[i] <= PW'(i);
    end else if (strobe.fire) begin
      for (int k = 0; k < W; k++) begin
        if (alloc[k]) mapTab[dstArr[k]] <= newTag[k];
      end
    end
  end

  // Output registers
  always_ff @(posedge clk) begin
    if (rst || strobe.outClear) begin
      outInstValid <= '0;
      outSrcTagA   <= '0;
      outSrcTagB   <= '0;
      outReadEnA   <= '0;
      outReadEnB   <= '0;
      outDstTag    <= '0;
      outOldTag    <= '0;
    end else if (strobe.outLoad) begin
      outInstValid <= instValid;
      outReadEnA   <= readA;
      outReadEnB   <= readB;
      for (int k = 0; k < W; k++) begin
        outSrcTagA[k*PW +: PW] <= tagA[k];
        outSrcTagB[k*PW +: PW] <= tagB[k];
        outDstTag[k*PW +: PW]  <= newTag[k];
        outOldTag[k*PW +: PW]  <= oldTag[k];
      end
    end
  end

  generate
    for (genvar k = 0; k < W; k++) begin : g_chk
      // R5
      alloc_range_chk: assert property (@(posedge clk) disable iff (rst)
        (outInstValid[k] && outDstTag[k*PW +: PW] != '0) |->
          (int'(outDstTag[k*PW +: PW]) >= ARCH_REGS));
      // R8
      zero_old_chk: assert property (@(posedge clk) disable iff (rst)
        (outDstTag[k*PW +: PW] == '0) |-> (outOldTag[k*PW +: PW] == '0));
      // R10
      idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !outInstValid[k] |-> (!outReadEnA[k] && !outReadEnB[k]));
    end
  endgenerate

endmodule

// File: rtl/rename_stage.sv
module rename_stage import rename_pkg::*; #(
  parameter int W = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 96,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int NW = $clog2(W + 1),
  localparam int CW = $clog2(PHYS_REGS - ARCH_REGS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output logic            inReady,
  input  logic [W-1:0]    instValid,
  input  logic [W*AW-1:0] srcA,
  input  logic [W*AW-1:0] srcB,
  input  logic [W*AW-1:0] dst,
  output logic            outValid,
  output logic [W-1:0]    outInstValid,
  output logic [W*PW-1:0] outSrcTagA,
  output logic [W*PW-1:0] outSrcTagB,
  output logic [W-1:0]    outReadEnA,
  output logic [W-1:0]    outReadEnB,
  output logic [W*PW-1:0] outDstTag,
  output logic [W*PW-1:0] outOldTag
);

  renameStrobe_t strobe;
  logic [CW-1:0]   freeCount;
  logic [NW-1:0]   popCnt;
  logic [W*PW-1:0] peekTags;

  rename_ctrl #(.W(W), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .freeCount(freeCount),
    .inReady(inReady), .strobe(strobe), .outValid(outValid)
  );

  rename_freelist #(.W(W), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk(clk), .rst(rst), .popEn(strobe.fire), .popCnt(popCnt),
    .peekTags(peekTags), .freeCount(freeCount)
  );

  rename_datapath #(.W(W), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .instValid(instValid),
    .srcA(srcA), .srcB(srcB), .dst(dst), .peekTags(peekTags), .popCnt(popCnt),
    .outInstValid(outInstValid), .outSrcTagA(outSrcTagA), .outSrcTagB(outSrcTagB),
    .outReadEnA(outReadEnA), .outReadEnB(outReadEnB),
    .outDstTag(outDstTag), .outOldTag(outOldTag)
  );

endmodule

// File: tb/rename_stage_bench.sv
module rename_stage_bench;
  localparam int W = 4;
  localparam int AR = 16;
  localparam int PR = 64;
  localparam int AW = 4;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inReady;
  logic [W-1:0]    instValid = '0;
  logic [W*AW-1:0] srcA = '0, srcB = '0, dst = '0;
  logic            outValid;
  logic [W-1:0]    outInstValid, outReadEnA, outReadEnB;
  logic [W*PW-1:0] outSrcTagA, outSrcTagB, outDstTag, outOldTag;

  always #2 clk = ~clk;

  rename_stage #(.W(W), .ARCH_REGS(AR), .PHYS_REGS(PR)) u_rename_stage (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .instValid(instValid), .srcA(srcA), .srcB(srcB), .dst(dst),
    .outValid(outValid), .outInstValid(outInstValid),
    .outSrcTagA(outSrcTagA), .outSrcTagB(outSrcTagB),
    .outReadEnA(outReadEnA), .outReadEnB(outReadEnB),
    .outDstTag(outDstTag), .outOldTag(outOldTag)
  );

  typedef struct packed {
    logic [W-1:0]    iv;
    logic [W*PW-1:0] ta, tb;
    logic [W-1:0]    ea, eb;
    logic [W*PW-1:0] dt, ot;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int checks = 0;
  int fails = 0;
  int modelTab[AR];
  int nextTag;
  int freeLeft;
  bit done = 0;

  task automatic chk(input string label, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", label, act, exp);
    end
  endtask

  // Driver: applies a group at a negedge and pushes the expected result.
  task automatic sendGroup(input string label, input logic [W-1:0] v,
                           input int a[W], input int b[W], input int d[W]);
    expItem_t e;
    int newT[W];
    bit al[W];
    bit expReady;
    for (int k = 0; k < W; k++) begin
      srcA[k*AW +: AW] = AW'(a[k]);
      srcB[k*AW +: AW] = AW'(b[k]);
      dst[k*AW +: AW]  = AW'(d[k]);
    end
    instValid = v;
    inValid = 1'b1;
    #1;
    expReady = (freeLeft >= W);
    chk({label, " R9 inReady"}, 64'(inReady), 64'(expReady));
    if (expReady) begin
      e = '0;
      e.iv = v;
      for (int k = 0; k < W; k++) begin
        al[k] = v[k] && d[k] != 0;
        newT[k] = 0;
        if (al[k]) begin newT[k] = nextTag; nextTag++; freeLeft--; end
      end
      for (int k = 0; k < W; k++) begin
        int ta, tb, ot;
        bit ea, eb;
        ta = (v[k] && a[k] != 0) ? modelTab[a[k]] : 0;
        ea = v[k] && a[k] != 0;
        tb = (v[k] && b[k] != 0) ? modelTab[b[k]] : 0;
        eb = v[k] && b[k] != 0;
        ot = al[k] ? modelTab[d[k]] : 0;
        for (int j = 0; j < k; j++) begin
          if (al[j] && ea && d[j] == a[k]) ta = newT[j];
          if (al[j] && eb && d[j] == b[k]) tb = newT[j];
          if (al[j] && al[k] && d[j] == d[k]) ot = newT[j];
        end
        for (int j = 0; j < k; j++) begin
          if (al[j] && v[k] && a[k] != 0 && d[j] == a[k]) ea = 0;
          if (al[j] && v[k] && b[k] != 0 && d[j] == b[k]) eb = 0;
        end
        e.ta[k*PW +: PW] = PW'(ta);
        e.tb[k*PW +: PW] = PW'(tb);
        e.ea[k] = ea;
        e.eb[k] = eb;
        e.dt[k*PW +: PW] = PW'(newT[k]);
        e.ot[k*PW +: PW] = PW'(ot);
      end
      for (int k = 0; k < W; k++) if (al[k]) modelTab[d[k]] = newT[k];
      expQ.push_back(e);
      tagQ.push_back(label);
      @(posedge clk);
      @(negedge clk);
      inValid = 1'b0;
    end else begin
      // R9: a stalled group must produce nothing while held
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk({label, " R9 no output while stalled"}, 64'(outValid), 64'(0));
        chk({label, " R9 still stalled"}, 64'(inReady), 64'(0));
      end
      inValid = 1'b0;
    end
  endtask

  // Monitor: pops and compares whenever a result is presented
  always @(negedge clk) begin
    if (!rst && !done && outValid) begin
      if (expQ.size() == 0) begin
        chk("R11 unexpected output", 64'(outValid), 64'(0));
      end else begin
        expItem_t e;
        string l;
        e = expQ.pop_front();
        l = tagQ.pop_front();
        chk({l, " R10 outInstValid"}, 64'(outInstValid), 64'(e.iv));
        chk({l, " R2 R3 R4 R8 srcTagA"}, 64'(outSrcTagA), 64'(e.ta));
        chk({l, " R2 R3 R4 R8 srcTagB"}, 64'(outSrcTagB), 64'(e.tb));
        chk({l, " R2 R3 R8 readEnA"}, 64'(outReadEnA), 64'(e.ea));
        chk({l, " R2 R3 R8 readEnB"}, 64'(outReadEnB), 64'(e.eb));
        chk({l, " R5 R8 dstTag"}, 64'(outDstTag), 64'(e.dt));
        chk({l, " R6 R8 oldTag"}, 64'(outOldTag), 64'(e.ot));
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < AR; i++) modelTab[i] = i;
    nextTag = AR;
    freeLeft = PR - AR;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs and ready after reset
    chk("R1 outValid after reset", 64'(outValid), 64'(0));
    chk("R1 inReady after reset", 64'(inReady), 64'(1));

    // R1 R2 R5: independent group reads the identity mapping
    sendGroup("R1 R2 R5 independent", 4'b1111, '{5, 7, 9, 11}, '{6, 8, 10, 12}, '{1, 2, 3, 4});
    // R3 R6: chained dependencies, repeated destination
    sendGroup("R3 R6 chain", 4'b1111, '{1, 5, 6, 7}, '{2, 3, 5, 0}, '{5, 6, 7, 5});
    // R4 R7: several writers of one register
    sendGroup("R4 R7 multi-writer", 4'b1111, '{3, 8, 8, 8}, '{4, 1, 8, 8}, '{8, 8, 8, 9});
    // R8 R10: register 0 and an invalid slot
    sendGroup("R8 R10 zero and idle", 4'b1011, '{0, 0, 11, 3}, '{8, 9, 12, 0}, '{0, 3, 10, 0});
    // R7: reads only, shows which writer the table kept
    sendGroup("R7 youngest kept", 4'b1111, '{8, 9, 1, 7}, '{5, 3, 6, 4}, '{0, 0, 0, 0});

    for (int n = 0; n < 200 && freeLeft >= W; n++) begin
      int a[W], b[W], d[W];
      logic [W-1:0] v;
      v = W'($urandom);
      for (int k = 0; k < W; k++) begin
        a[k] = int'($urandom_range(0, AR - 1));
        b[k] = int'($urandom_range(0, AR - 1));
        d[k] = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, AR - 1));
      end
      sendGroup("R2 R3 R4 R5 R6 R7 R8 R10 random", v, a, b, d);
    end

    // R9: fewer than W tags are left now
    sendGroup("R9 stall", 4'b1111, '{1, 2, 3, 4}, '{5, 6, 7, 8}, '{1, 2, 3, 4});

    repeat (3) @(negedge clk);
    chk("R11 every accepted group produced one output", 64'(expQ.size()), 64'(0));
    finishRun();
  end

endmodule